// File: doc/BRIEF.md
# Snooping Write-Back Line Coherence Controller

This block keeps a small direct-mapped array of cache lines coherent on a shared snooping bus. Each line is held in one of three states: invalid, shared (clean, read-only, possibly held elsewhere) or modified (the only valid copy, dirty). A processor port issues reads and writes. Hits are answered in the same cycle. Misses and permission upgrades become bus requests: read-for-share, read-for-ownership, or an upgrade without data. When a dirty line is displaced, a writeback request goes out first.

A snoop port presents every transaction that other agents put on the bus. The controller looks up the addressed line. It then downgrades or invalidates that line and, when the line was dirty, drives its data out on a flush port one cycle later. Arbitration and memory sit outside the block. The block only raises a request, waits for a grant, and then waits for a completion strobe that may carry fill data.

Top module: `msi_line_ctrl`

## Requirements
- R1: A read that misses (line invalid or tag differs) raises a request with command code 1 (read-for-share) at the full address {tag, index}, where the index is the low address bits. On completion the line becomes shared and holds the fill data, which is returned to the processor with the hit flag low.
- R2: A write that misses raises command code 2 (read-for-ownership). On completion the line becomes modified and holds the written word.
- R3: A write to a shared line with a matching tag raises command code 3 (upgrade). On completion the line becomes modified with the written word, and the fill bus is ignored.
- R4: A read of a shared or modified line, or a write to a modified line, with a matching tag raises ready and hit in the same cycle. It makes no bus request and leaves the line state unchanged; a write updates the data.
- R5: A snooped code 1 that hits a modified line pulses the flush output one cycle later with the line data, and the line becomes shared. A snooped code 1 that hits a shared line changes nothing and does not flush.
- R6: A snooped code 2 or 3 that hits a shared line invalidates it without a flush. If it hits a modified line, it flushes the data and invalidates the line.
- R7: A snoop whose line is invalid, or whose tag differs from the stored tag, has no effect and does not flush.
- R8: A miss that displaces a modified line first issues command code 4 (writeback) at the old line's address, carrying its data, and only then issues the fill request. Displacing a shared or invalid line issues no writeback.
- R9: A snoop whose requester ID equals the block's own ID is ignored.
- R10: If a pending upgrade has not yet been granted and a foreign code 2 or 3 snoop invalidates the same line, the pending command changes to code 2.
- R11: After reset every line is invalid and all outputs are low. A processor request that misses keeps ready low until the grant has been received and the completion has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | Processor request present, held until ready |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Request address {tag, index} |
| cpuWdata | input | DATA_W | Write word |
| cpuReady | output | 1 | Request finishes this cycle |
| cpuHit | output | 1 | With ready: request hit without bus traffic |
| cpuRdata | output | DATA_W | Read word, valid with ready |
| busReqValid | output | 1 | Bus request pending, held until grant |
| busReqCmd | output | 3 | 1 share-read, 2 own-read, 3 upgrade, 4 writeback |
| busReqAddr | output | ADDR_W | Request address |
| busReqData | output | DATA_W | Writeback data |
| busGrant | input | 1 | One-cycle grant of the request |
| busDone | input | 1 | One-cycle completion of the granted request |
| busFillData | input | DATA_W | Fill word, valid with busDone |
| snpValid | input | 1 | Snooped transaction present |
| snpCmd | input | 3 | Snooped command code |
| snpAddr | input | ADDR_W | Snooped address |
| snpSrcId | input | ID_W | Requester ID of the snooped transaction |
| snpFlush | output | 1 | Dirty-data flush pulse, one cycle after the snoop |
| snpFlushData | output | DATA_W | Flushed word |

## Verification
The hardest situation to reach is the upgrade race. A line must be shared, a write must turn it into a pending upgrade, and another agent's ownership request must hit that same line before the grant arrives. The bench reaches it by loading a line and downgrading it with a foreign read snoop. It then withholds the grant from its bus model and injects the ownership snoop while the request is stalled. Finally it observes the command change at the port before it releases the grant. Eviction writebacks are reached by writing an address that shares an index with a dirty line and differs in tag.

// File: rtl/msi_line_pkg.sv
package msi_line_pkg;

  typedef enum logic [1:0] {
    LINE_I = 2'd0,
    LINE_S = 2'd1,
    LINE_M = 2'd2
  } lineState_t;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_RD   = 3'd1,
    CMD_RDX  = 3'd2,
    CMD_UPGR = 3'd3,
    CMD_WB   = 3'd4
  } busCmd_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WBREQ,
    ST_WBWAIT,
    ST_REQ,
    ST_WAIT,
    ST_RESP
  } ctlState_t;

  // strobes from control to the line store
  typedef struct packed {
    logic       cpuWr;      // write processor word into addressed line
    logic       fillWr;     // install tag, state and data on completion
    lineState_t fillState;
    logic       fillFromBus; // data from fill bus (else processor word)
    logic       evict;      // mark processor-indexed line invalid
    logic       snpWr;      // update snooped line state
    lineState_t snpState;
    logic       flushCap;   // capture snooped line data for flush
  } ctrlStrobe_t;

endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_line_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int TAG_W     = 4,
  parameter int DATA_W    = 8,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [IDX_W-1:0]  cpuIdx,
  input  logic [TAG_W-1:0]  cpuTag,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] busFillData,
  input  logic [IDX_W-1:0]  snpIdx,
  output lineState_t        cpuLineState,
  output logic [TAG_W-1:0]  cpuLineTag,
  output logic [DATA_W-1:0] cpuLineData,
  output lineState_t        snpLineState,
  output logic [TAG_W-1:0]  snpLineTag,
  output logic              snpFlush,
  output logic [DATA_W-1:0] snpFlushData
);

  lineState_t        stateArr [NUM_LINES];
  logic [TAG_W-1:0]  tagArr   [NUM_LINES];
  logic [DATA_W-1:0] dataArr  [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    logic cpuSel, snpSel;
    assign cpuSel = (cpuIdx == IDX_W'(g));
    assign snpSel = (snpIdx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stateArr[g] <= LINE_I;
        tagArr[g]   <= '0;
        dataArr[g]  <= '0;
      end else begin
        // later statements take priority
        if (strobe.snpWr && snpSel)   stateArr[g] <= strobe.snpState;
        if (strobe.evict && cpuSel)   stateArr[g] <= LINE_I;
        if (strobe.fillWr && cpuSel) begin
          stateArr[g] <= strobe.fillState;
          tagArr[g]   <= cpuTag;
          dataArr[g]  <= strobe.fillFromBus ? busFillData : cpuWdata;
        end
        if (strobe.cpuWr && cpuSel)   dataArr[g]  <= cpuWdata;
      end
    end
  end

  assign cpuLineState = stateArr[cpuIdx];
  assign cpuLineTag   = tagArr[cpuIdx];
  assign cpuLineData  = dataArr[cpuIdx];
  assign snpLineState = stateArr[snpIdx];
  assign snpLineTag   = tagArr[snpIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      snpFlush     <= 1'b0;
      snpFlushData <= '0;
    end else begin
      snpFlush     <= strobe.flushCap;
      snpFlushData <= strobe.flushCap ? dataArr[snpIdx] : '0;
    end
  end

endmodule

// File: rtl/msi_line_fsm.sv
module msi_line_fsm
  import msi_line_pkg::*;
#(
  parameter int TAG_W = 4,
  parameter int IDX_W = 2,
  parameter int ID_W  = 2,
  parameter int MY_ID = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuValid,
  input  logic             cpuWrite,
  input  logic [TAG_W-1:0] cpuTag,
  input  logic [IDX_W-1:0] cpuIdx,
  input  lineState_t       cpuLineState,
  input  logic [TAG_W-1:0] cpuLineTag,
  input  logic             snpValid,
  input  busCmd_t          snpCmd,
  input  logic [TAG_W-1:0] snpTag,
  input  logic [IDX_W-1:0] snpIdx,
  input  logic [ID_W-1:0]  snpSrcId,
  input  lineState_t       snpLineState,
  input  logic [TAG_W-1:0] snpLineTag,
  input  logic             busGrant,
  input  logic             busDone,
  output logic             cpuReady,
  output logic             cpuHit,
  output logic             busReqValid,
  output busCmd_t          busReqCmd,
  output logic             useOldTag,
  output ctrlStrobe_t      strobe
);

  ctlState_t st, nextSt;
  busCmd_t   pendCmd, nextCmd;

  logic    tagHit, isHit, snpRelevant, snpKillsOwn, sameIdxSnoop;
  busCmd_t missCmd;

  assign tagHit = (cpuLineTag == cpuTag) && (cpuLineState != LINE_I);
  assign isHit  = tagHit && ((cpuLineState == LINE_M) ||
                             (cpuLineState == LINE_S && !cpuWrite));
  assign missCmd = !cpuWrite ? CMD_RD :
                   (tagHit && cpuLineState == LINE_S) ? CMD_UPGR : CMD_RDX;

  assign snpRelevant = snpValid && (snpSrcId != ID_W'(MY_ID)) &&
                       (snpLineState != LINE_I) && (snpLineTag == snpTag);
  assign snpKillsOwn = snpRelevant && (snpCmd == CMD_RDX || snpCmd == CMD_UPGR) &&
                       (snpIdx == cpuIdx) && (snpTag == cpuTag);
  assign sameIdxSnoop = snpValid && (snpIdx == cpuIdx);

  always_comb begin
    strobe      = '0;
    cpuReady    = 1'b0;
    cpuHit      = 1'b0;
    busReqValid = 1'b0;
    busReqCmd   = CMD_NONE;
    useOldTag   = 1'b0;
    nextSt      = st;
    nextCmd     = pendCmd;

    // snoop response, independent of the processor side
    if (snpRelevant) begin
      unique case (snpCmd)
        CMD_RD: if (snpLineState == LINE_M) begin
          strobe.snpWr    = 1'b1;
          strobe.snpState = LINE_S;
          strobe.flushCap = 1'b1;
        end
        CMD_RDX, CMD_UPGR: begin
          strobe.snpWr    = 1'b1;
          strobe.snpState = LINE_I;
          strobe.flushCap = (snpLineState == LINE_M);
        end
        default: ;
      endcase
    end

    unique case (st)
      ST_IDLE: if (cpuValid && !sameIdxSnoop) begin
        if (isHit) begin
          cpuReady     = 1'b1;
          cpuHit       = 1'b1;
          strobe.cpuWr = cpuWrite;
        end else if (cpuLineState == LINE_M && !tagHit) begin
          nextSt = ST_WBREQ;
        end else begin
          nextSt  = ST_REQ;
          nextCmd = missCmd;
        end
      end
      ST_WBREQ: begin
        if (cpuLineState != LINE_M) begin
          // dirty line was snooped away meanwhile: eviction is now silent
          nextSt  = ST_REQ;
          nextCmd = missCmd;
        end else begin
          busReqValid = 1'b1;
          busReqCmd   = CMD_WB;
          useOldTag   = 1'b1;
          if (busGrant) nextSt = ST_WBWAIT;
        end
      end
      ST_WBWAIT: begin
        useOldTag = 1'b1;
        if (busDone) begin
          strobe.evict = 1'b1;
          nextSt       = ST_REQ;
          nextCmd      = missCmd;
        end
      end
      ST_REQ: begin
        busReqValid = 1'b1;
        busReqCmd   = pendCmd;
        if (pendCmd == CMD_UPGR && snpKillsOwn) nextCmd = CMD_RDX;
        if (busGrant) nextSt = ST_WAIT;
      end
      ST_WAIT: if (busDone) begin
        strobe.fillWr      = 1'b1;
        strobe.fillState   = (pendCmd == CMD_RD) ? LINE_S : LINE_M;
        strobe.fillFromBus = (pendCmd == CMD_RD);
        nextSt             = ST_RESP;
      end
      ST_RESP: begin
        cpuReady = 1'b1;
        nextSt   = ST_IDLE;
      end
      default: nextSt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st      <= ST_IDLE;
      pendCmd <= CMD_NONE;
    end else begin
      st      <= nextSt;
      pendCmd <= nextCmd;
    end
  end

endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
  import msi_line_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int TAG_W     = 4,
  parameter int DATA_W    = 8,
  parameter int ID_W      = 2,
  parameter int MY_ID     = 0,
  localparam int IDX_W    = $clog2(NUM_LINES),
  localparam int ADDR_W   = TAG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic              cpuHit,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busReqValid,
  output logic [2:0]        busReqCmd,
  output logic [ADDR_W-1:0] busReqAddr,
  output logic [DATA_W-1:0] busReqData,
  input  logic              busGrant,
  input  logic              busDone,
  input  logic [DATA_W-1:0] busFillData,
  input  logic              snpValid,
  input  logic [2:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic [ID_W-1:0]   snpSrcId,
  output logic              snpFlush,
  output logic [DATA_W-1:0] snpFlushData
);

  logic [IDX_W-1:0] cpuIdx, snpIdx;
  logic [TAG_W-1:0] cpuTag, snpTag, cpuLineTag, snpLineTag;
  lineState_t       cpuLineState, snpLineState;
  logic [DATA_W-1:0] cpuLineData;
  ctrlStrobe_t      strobe;
  busCmd_t          reqCmd;
  logic             useOldTag;

  assign cpuIdx = cpuAddr[IDX_W-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:IDX_W];
  assign snpIdx = snpAddr[IDX_W-1:0];
  assign snpTag = snpAddr[ADDR_W-1:IDX_W];

  msi_line_fsm #(
    .TAG_W(TAG_W), .IDX_W(IDX_W), .ID_W(ID_W), .MY_ID(MY_ID)
  ) u_fsm (
    .clk(clk), .rstN(rstN),
    .cpuValid(cpuValid), .cpuWrite(cpuWrite),
    .cpuTag(cpuTag), .cpuIdx(cpuIdx),
    .cpuLineState(cpuLineState), .cpuLineTag(cpuLineTag),
    .snpValid(snpValid), .snpCmd(busCmd_t'(snpCmd)),
    .snpTag(snpTag), .snpIdx(snpIdx), .snpSrcId(snpSrcId),
    .snpLineState(snpLineState), .snpLineTag(snpLineTag),
    .busGrant(busGrant), .busDone(busDone),
    .cpuReady(cpuReady), .cpuHit(cpuHit),
    .busReqValid(busReqValid), .busReqCmd(reqCmd),
    .useOldTag(useOldTag), .strobe(strobe)
  );

  msi_line_store #(
    .NUM_LINES(NUM_LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cpuIdx(cpuIdx), .cpuTag(cpuTag), .cpuWdata(cpuWdata),
    .busFillData(busFillData), .snpIdx(snpIdx),
    .cpuLineState(cpuLineState), .cpuLineTag(cpuLineTag),
    .cpuLineData(cpuLineData),
    .snpLineState(snpLineState), .snpLineTag(snpLineTag),
    .snpFlush(snpFlush), .snpFlushData(snpFlushData)
  );

  assign busReqCmd  = 3'(reqCmd);
  assign busReqAddr = useOldTag ? {cpuLineTag, cpuIdx} : cpuAddr;
  assign busReqData = cpuLineData;
  assign cpuRdata   = cpuLineData;

endmodule

// File: rtl/msi_line_chk.sv
module msi_line_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int ID_W   = 2,
  parameter int MY_ID  = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuValid,
  input logic              cpuWrite,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic [DATA_W-1:0] cpuWdata,
  input logic              cpuReady,
  input logic              cpuHit,
  input logic [DATA_W-1:0] cpuRdata,
  input logic              busReqValid,
  input logic [2:0]        busReqCmd,
  input logic [ADDR_W-1:0] busReqAddr,
  input logic [DATA_W-1:0] busReqData,
  input logic              busGrant,
  input logic              busDone,
  input logic [DATA_W-1:0] busFillData,
  input logic              snpValid,
  input logic [2:0]        snpCmd,
  input logic [ADDR_W-1:0] snpAddr,
  input logic [ID_W-1:0]   snpSrcId,
  input logic              snpFlush,
  input logic [DATA_W-1:0] snpFlushData
);

  assert_flush_needs_foreign_snoop_R9: assert property (@(posedge clk) disable iff (!rstN)
    snpFlush |-> ($past(snpValid) && $past(snpSrcId) != ID_W'(MY_ID)));

  assert_flush_after_snoop_R5: assert property (@(posedge clk) disable iff (!rstN)
    snpFlush |-> $past(snpCmd) inside {3'd1, 3'd2, 3'd3});

  assert_req_code_legal_R8: assert property (@(posedge clk) disable iff (!rstN)
    busReqValid |-> busReqCmd inside {3'd1, 3'd2, 3'd3, 3'd4});

  assert_stall_while_req_R11: assert property (@(posedge clk) disable iff (!rstN)
    busReqValid |-> !cpuReady);

  assert_hit_with_ready_R4: assert property (@(posedge clk) disable iff (!rstN)
    cpuHit |-> cpuReady);

  assert_req_held_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busReqValid && !busGrant && busReqCmd != 3'd4) |=> (busReqValid && $stable(busReqAddr)));

  assert_upgr_only_to_rdx_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busReqValid) && !$past(busGrant) && $past(busReqCmd) == 3'd3 && busReqValid)
      |-> busReqCmd inside {3'd2, 3'd3});

endmodule

bind msi_line_ctrl msi_line_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .MY_ID(MY_ID)
) u_chk (.*);

// File: tb/msi_line_ctrl_tb.sv
module msi_line_ctrl_tb;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int ID_W   = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuValid = 0, cpuWrite = 0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic [DATA_W-1:0] cpuWdata = '0;
  logic cpuReady, cpuHit;
  logic [DATA_W-1:0] cpuRdata;
  logic busReqValid;
  logic [2:0] busReqCmd;
  logic [ADDR_W-1:0] busReqAddr;
  logic [DATA_W-1:0] busReqData;
  logic busGrant = 0, busDone = 0;
  logic [DATA_W-1:0] busFillData = '0;
  logic snpValid = 0;
  logic [2:0] snpCmd = '0;
  logic [ADDR_W-1:0] snpAddr = '0;
  logic [ID_W-1:0] snpSrcId = '0;
  logic snpFlush;
  logic [DATA_W-1:0] snpFlushData;

  always #2 clk = ~clk;

  msi_line_ctrl u_dut (.*);

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // memory and bus model
  logic [DATA_W-1:0] mem [64];
  logic [2:0] cmdLog [64];
  logic [ADDR_W-1:0] addrLog [64];
  logic [DATA_W-1:0] dataLog [64];
  int logLen = 0;
  bit holdGrant = 0;
  int phase = 0, cnt = 0;
  logic [2:0] curCmd;
  logic [ADDR_W-1:0] curAddr;
  logic [DATA_W-1:0] curData;

  initial for (int a = 0; a < 64; a++) mem[a] = DATA_W'(a * 7 + 3);

  always @(negedge clk) begin
    busGrant = 0;
    busDone  = 0;
    if (!rstN) phase = 0;
    else if (phase == 0) begin
      if (busReqValid && !holdGrant) begin
        busGrant = 1;
        curCmd = busReqCmd; curAddr = busReqAddr; curData = busReqData;
        cmdLog[logLen] = busReqCmd; addrLog[logLen] = busReqAddr;
        dataLog[logLen] = busReqData;
        logLen++;
        phase = 1; cnt = 0;
      end
    end else begin
      cnt++;
      if (cnt == 2) begin
        busDone = 1;
        busFillData = mem[curAddr];
        if (curCmd == 3'd4) mem[curAddr] = curData;
        phase = 0;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic cpuOp(input logic wr, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] d, output logic hit,
                       output logic [DATA_W-1:0] rd);
    @(posedge clk); #1;
    cpuValid = 1; cpuWrite = wr; cpuAddr = a; cpuWdata = d;
    #1;
    while (!cpuReady) begin @(posedge clk); #1; end
    hit = cpuHit; rd = cpuRdata;
    @(posedge clk); #1;
    cpuValid = 0; cpuWrite = 0;
  endtask

  task automatic snoop(input logic [2:0] c, input logic [ADDR_W-1:0] a,
                       input logic [ID_W-1:0] src, output logic fl,
                       output logic [DATA_W-1:0] fd);
    @(negedge clk);
    snpValid = 1; snpCmd = c; snpAddr = a; snpSrcId = src;
    @(negedge clk);
    snpValid = 0;
    fl = snpFlush; fd = snpFlushData;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic hit, fl;
    logic [DATA_W-1:0] rd, fd;
    int n0;

    repeat (3) @(posedge clk); #1;
    check("R11 reset ready", cpuReady, 0);
    check("R11 reset busReq", busReqValid, 0);
    check("R11 reset flush", snpFlush, 0);
    rstN = 1;

    // sweep every line: read miss, read hit, upgrade, write hit
    for (int i = 0; i < 4; i++) begin
      logic [ADDR_W-1:0] a;
      a = {4'(i + 1), 2'(i)};
      n0 = logLen;
      cpuOp(0, a, 0, hit, rd);
      check("R11 R1 miss after reset", hit, 0);
      check("R1 read data", rd, DATA_W'(a * 7 + 3));
      check("R1 one request", logLen - n0, 1);
      check("R1 cmd", cmdLog[n0], 1);
      check("R1 addr", addrLog[n0], a);
      cpuOp(0, a, 0, hit, rd);
      check("R4 read hit", hit, 1);
      check("R4 no traffic", logLen - n0, 1);
      cpuOp(1, a, DATA_W'(8'hA0 + i), hit, rd);
      check("R3 upgrade miss flag", hit, 0);
      check("R3 upgrade cmd", cmdLog[logLen - 1], 3);
      cpuOp(0, a, 0, hit, rd);
      check("R3 written data", rd, DATA_W'(8'hA0 + i));
      n0 = logLen;
      cpuOp(1, a, DATA_W'(8'hB0 + i), hit, rd);
      check("R4 write hit", hit, 1);
      check("R4 write no traffic", logLen - n0, 0);
    end

    // snooped share-read on modified line 0
    snoop(1, 6'h04, 1, fl, fd);
    check("R5 flush on M", fl, 1);
    check("R5 flush data", fd, 8'hB0);
    n0 = logLen;
    cpuOp(0, 6'h04, 0, hit, rd);
    check("R5 still readable", hit, 1);
    cpuOp(1, 6'h04, 8'hC0, hit, rd);
    check("R5 downgraded to S", cmdLog[logLen - 1], 3);
    check("R5 one upgrade", logLen - n0, 1);
    snoop(1, 6'h04, 2, fl, fd);   // dummy? no: cmd 1 on M again handled below
    // line now shared again after the above flush; write back to M
    cpuOp(1, 6'h04, 8'hC1, hit, rd);
    snoop(1, 6'h04, 3, fl, fd);
    check("R5 flush again", fl, 1);
    snoop(1, 6'h04, 3, fl, fd);
    check("R5 no flush on S", fl, 0);
    cpuOp(0, 6'h04, 0, hit, rd);
    check("R5 S unchanged", hit, 1);
    cpuOp(1, 6'h04, 8'hC1, hit, rd);   // back to M via upgrade

    // own-ID snoop ignored
    snoop(1, 6'h04, 0, fl, fd);
    check("R9 own snoop no flush", fl, 0);
    n0 = logLen;
    cpuOp(1, 6'h04, 8'hC2, hit, rd);
    check("R9 still M", hit, 1);
    check("R9 no traffic", logLen - n0, 0);

    // ownership snoop on M, then upgrade snoop on S
    snoop(2, 6'h04, 2, fl, fd);
    check("R6 flush on M", fl, 1);
    check("R6 flush data", fd, 8'hC2);
    cpuOp(0, 6'h04, 0, hit, rd);
    check("R6 invalid after M", hit, 0);
    check("R6 refetch cmd", cmdLog[logLen - 1], 1);
    snoop(3, 6'h04, 1, fl, fd);
    check("R6 no flush on S", fl, 0);
    cpuOp(0, 6'h04, 0, hit, rd);
    check("R6 invalid after S", hit, 0);

    // tag mismatch and invalid lines ignore snoops
    snoop(2, 6'h14, 1, fl, fd);
    check("R7 tag mismatch no flush", fl, 0);
    cpuOp(0, 6'h04, 0, hit, rd);
    check("R7 line kept", hit, 1);
    snoop(2, 6'h04, 1, fl, fd);
    snoop(1, 6'h04, 1, fl, fd);
    check("R7 invalid no flush", fl, 0);
    cpuOp(1, 6'h04, 8'hD0, hit, rd);
    check("R2 write miss", hit, 0);
    check("R2 cmd", cmdLog[logLen - 1], 2);
    cpuOp(0, 6'h04, 0, hit, rd);
    check("R2 M hit", hit, 1);
    check("R2 data", rd, 8'hD0);

    // eviction of modified line 1 (addr 0x09, data B1)
    n0 = logLen;
    cpuOp(1, 6'h19, 8'hE1, hit, rd);
    check("R8 two requests", logLen - n0, 2);
    check("R8 writeback cmd", cmdLog[n0], 4);
    check("R8 writeback addr", addrLog[n0], 6'h09);
    check("R8 writeback data", dataLog[n0], 8'hB1);
    check("R8 fill after wb", cmdLog[n0 + 1], 2);
    check("R8 memory updated", mem[6'h09], 8'hB1);
    n0 = logLen;
    cpuOp(0, 6'h09, 0, hit, rd);
    check("R8 evict M again", cmdLog[n0], 4);
    check("R8 read data back", rd, 8'hB1);
    n0 = logLen;
    cpuOp(0, 6'h19, 0, hit, rd);
    check("R8 silent S eviction", logLen - n0, 1);
    check("R8 silent cmd", cmdLog[n0], 1);
    check("R8 data from memory", rd, 8'hE1);

    // upgrade race on line 2 (addr 0x0E, M data B2)
    snoop(1, 6'h0E, 1, fl, fd);
    check("R5 race setup flush", fd, 8'hB2);
    holdGrant = 1;
    fork
      cpuOp(1, 6'h0E, 8'h55, hit, rd);
      begin
        repeat (4) @(negedge clk);
        check("R10 pending upgrade", busReqCmd, 3);
        check("R11 stalled", cpuReady, 0);
        snoop(2, 6'h0E, 3, fl, fd);
        check("R10 snoop no flush", fl, 0);
        check("R10 reissued", busReqCmd, 2);
        check("R10 still requesting", busReqValid, 1);
        holdGrant = 0;
      end
    join
    check("R10 granted cmd", cmdLog[logLen - 1], 2);
    cpuOp(0, 6'h0E, 0, hit, rd);
    check("R10 line M", hit, 1);
    check("R10 data", rd, 8'h55);

    summary();
  end
endmodule